// File: doc/BRIEF.md
# Oscillator Frequency Auto-Detector

The block measures an oscillator of unknown frequency against a slow reference clock of nominally 32.768 kHz. A trigger write on a small register bus starts a measurement. The block then counts oscillator cycles across a programmable number of reference periods and shows a busy flag while the count runs. At the end it returns the count in a status register.

When the measurement ends, the count is compared against four target counts, one for each supported crystal: 12, 13, 19.2 and 26 MHz. The comparison allows a tolerance of ±3. On a match, the block writes the matching code into a two-bit frequency field of the oscillator control register and leaves every other bit of that register as it was. On no match, the register keeps its value. Software boots with the field at its 13 MHz default and lets the detector correct it.

Top module: `osc_freq_detect`

## Requirements
- R1: After reset the status register reads 0, the detection control register reads 0, and the oscillator control register reads 0x1000_0000, which is the 13 MHz code (1) in field bits 29:28.
- R2: A write to address 0 with bit 31 set while idle starts a measurement. Status bit 31 (busy) reads 1 from the next cycle until the result is captured.
- R3: With window setting N (address 0, bits 3:0), the count in status bits 15:0 is the number of oscillator cycles between one rising edge of the reference clock and the rising edge N+1 reference periods later.
- R4: The count saturates at 0xFFFF instead of wrapping.
- R5: For window N the target count for code k is floor(B_k·(N+1)/2), with B = 732, 794, 1172, 1587 and codes 0=12 MHz, 1=13 MHz, 2=19.2 MHz, 3=26 MHz. A count within ±3 (inclusive) of a target selects that code.
- R6: On a match, only bits 29:28 of the oscillator control register take the new code, the other 30 bits keep their value, and status bit 30 reads 1.
- R7: On no match, the oscillator control register is unchanged and status bit 30 reads 0.
- R8: A write to address 0 while busy is ignored. The window readback stays the same and the running measurement is neither restarted nor resized.
- R9: The oscillator control register (address 2) stores and returns all 32 bits written by the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset for all domains |
| osc_clk_i | input | 1 | Oscillator being measured |
| ref_clk_i | input | 1 | Slow reference clock |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write enable |
| bus_addr_i | input | 2 | Register address: 0 detect control, 1 status, 2 oscillator control |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |

## Verification
The hardest conditions to reach are exact counts one step inside and one step outside each tolerance band, because the count depends on the phase between two free-running clocks. The bench sets the reference period so that N+1 periods are an exact multiple of the oscillator period. It also places every reference edge well clear of an oscillator edge, so each measurement lands on a chosen count. With this it sweeps target±3 and target±4 for all four codes, and it covers three other windows. A trigger written during a busy window and a very fast oscillator that drives the counter into saturation complete the coverage.

// File: rtl/ofd_pkg.sv
package ofd_pkg;
  localparam int NUM_FREQ = 4;
  localparam int CODE_W   = 2;

  typedef enum logic [CODE_W-1:0] {
    FREQ_12M  = 2'd0,
    FREQ_13M  = 2'd1,
    FREQ_19M2 = 2'd2,
    FREQ_26M  = 2'd3
  } freq_code_e;

  // oscillator cycles in two reference periods, indexed by code
  localparam logic [31:0] BASE_CNT [NUM_FREQ] = '{32'd732, 32'd794, 32'd1172, 32'd1587};

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_COUNT = 2'd2
  } meas_st_e;
endpackage

// File: rtl/ofd_sync.sv
module ofd_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      q_o  <= '0;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/ofd_meas.sv
module ofd_meas import ofd_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int WIN_W = 4
) (
  input  logic             osc_clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             start_tgl_i,
  input  logic [WIN_W-1:0] win_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_tgl_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic ref_s, ref_d, start_s, start_d;
  logic ref_rise, start_chg;
  meas_st_e st_q;
  logic [WIN_W-1:0] left_q;
  logic [CNT_W-1:0] cnt_q;
  logic done_q;

  ofd_sync #(.W(1)) u_ref_sync   (.clk_i(osc_clk_i), .rst_ni(rst_ni), .d_i(ref_i),       .q_o(ref_s));
  ofd_sync #(.W(1)) u_start_sync (.clk_i(osc_clk_i), .rst_ni(rst_ni), .d_i(start_tgl_i), .q_o(start_s));

  assign ref_rise  = ref_s & ~ref_d;
  assign start_chg = start_s ^ start_d;

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_d   <= 1'b0;
      start_d <= 1'b0;
      st_q    <= ST_IDLE;
      left_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      ref_d   <= ref_s;
      start_d <= start_s;
      unique case (st_q)
        ST_IDLE: if (start_chg) begin
          st_q   <= ST_ALIGN;
          left_q <= win_i;   // stable: bus side blocks writes while busy
        end
        ST_ALIGN: if (ref_rise) begin
          st_q  <= ST_COUNT;
          cnt_q <= '0;
        end
        ST_COUNT: begin
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
          if (ref_rise) begin
            if (left_q == '0) begin
              st_q   <= ST_IDLE;
              done_q <= ~done_q;
            end else begin
              left_q <= left_q - 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cnt_o      = cnt_q;
  assign done_tgl_o = done_q;

  AST_CNT_SATURATE: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (st_q == ST_COUNT && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R4
  AST_ALIGN_WAITS_EDGE: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (st_q == ST_ALIGN && !ref_rise) |=> (st_q == ST_ALIGN)); // R3
  AST_WINDOW_ENDS_ON_EDGE: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (st_q == ST_COUNT && !ref_rise) |=> (st_q == ST_COUNT)); // R3
endmodule

// File: rtl/ofd_classify.sv
module ofd_classify import ofd_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int WIN_W = 4,
  parameter int TOL   = 3
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [WIN_W-1:0]  win_i,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o
);
  logic [NUM_FREQ-1:0] hit_vec;
  logic [31:0] span;
  logic [31:0] cnt_w;

  assign span  = 32'(win_i) + 32'd1;
  assign cnt_w = 32'(cnt_i);

  for (genvar k = 0; k < NUM_FREQ; k++) begin : g_tgt
    logic [31:0] tgt;
    assign tgt        = (BASE_CNT[k] * span) >> 1;
    assign hit_vec[k] = (cnt_w + 32'(TOL) >= tgt) && (cnt_w <= tgt + 32'(TOL));
  end

  always_comb begin
    hit_o  = |hit_vec;
    code_o = '0;
    for (int k = NUM_FREQ - 1; k >= 0; k--) begin
      if (hit_vec[k]) code_o = CODE_W'(k);
    end
  end
endmodule

// File: rtl/osc_freq_detect.sv
module osc_freq_detect import ofd_pkg::*; #(
  parameter int CNT_W     = 16,
  parameter int WIN_W     = 4,
  parameter int TOL       = 3,
  parameter int FIELD_LSB = 28
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        osc_clk_i,
  input  logic        ref_clk_i,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o
);
  localparam logic [1:0]  ADDR_DET  = 2'd0;
  localparam logic [1:0]  ADDR_STAT = 2'd1;
  localparam logic [1:0]  ADDR_CTRL = 2'd2;
  localparam logic [31:0] FIELD_MASK = 32'((1 << CODE_W) - 1) << FIELD_LSB;
  localparam logic [31:0] CTRL_RST   = 32'(FREQ_13M) << FIELD_LSB;

  logic             busy_q, match_q, req_tgl_q, ack_d;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q, cnt_osc;
  logic [31:0]      ctrl_q;
  logic             done_tgl, ack_s, done;
  logic             wr_det, wr_ctrl, trig;
  logic             hit;
  logic [CODE_W-1:0] code;

  ofd_meas #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_meas (
    .osc_clk_i  (osc_clk_i),
    .rst_ni     (rst_ni),
    .ref_i      (ref_clk_i),
    .start_tgl_i(req_tgl_q),
    .win_i      (win_q),
    .cnt_o      (cnt_osc),
    .done_tgl_o (done_tgl)
  );

  ofd_sync #(.W(1)) u_ack_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(done_tgl), .q_o(ack_s));

  // count is quiet for two bus cycles once the toggle arrives
  ofd_classify #(.CNT_W(CNT_W), .WIN_W(WIN_W), .TOL(TOL)) u_cls (
    .cnt_i (cnt_osc),
    .win_i (win_q),
    .hit_o (hit),
    .code_o(code)
  );

  assign wr_det  = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_DET);
  assign wr_ctrl = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_CTRL);
  assign trig    = wr_det && !busy_q && bus_wdata_i[31];
  assign done    = busy_q && (ack_s ^ ack_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      match_q   <= 1'b0;
      req_tgl_q <= 1'b0;
      ack_d     <= 1'b0;
      win_q     <= '0;
      cnt_q     <= '0;
      ctrl_q    <= CTRL_RST;
    end else begin
      ack_d <= ack_s;
      if (wr_det && !busy_q) win_q <= bus_wdata_i[WIN_W-1:0];
      if (trig) begin
        busy_q    <= 1'b1;
        match_q   <= 1'b0;
        req_tgl_q <= ~req_tgl_q;
      end
      if (done) begin
        busy_q  <= 1'b0;
        match_q <= hit;
        cnt_q   <= cnt_osc;
      end
      if (wr_ctrl)         ctrl_q <= bus_wdata_i;
      else if (done && hit) ctrl_q[FIELD_LSB +: CODE_W] <= code;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      ADDR_DET:  bus_rdata_o[WIN_W-1:0] = win_q;
      ADDR_STAT: begin
        bus_rdata_o[31]        = busy_q;
        bus_rdata_o[30]        = match_q;
        bus_rdata_o[CNT_W-1:0] = cnt_q;
      end
      ADDR_CTRL: bus_rdata_o = ctrl_q;
      default:   bus_rdata_o = '0;
    endcase
  end

  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done) |=> busy_q); // R2
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && wr_det) |=> $stable(win_q)); // R8
  AST_NOMATCH_KEEPS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !hit && !wr_ctrl) |=> $stable(ctrl_q)); // R7
  AST_MATCH_KEEPS_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && hit && !wr_ctrl) |=> ((ctrl_q & ~FIELD_MASK) == ($past(ctrl_q) & ~FIELD_MASK))); // R6
  AST_CNT_STABLE_AT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> $stable(cnt_osc)); // R3
endmodule

// File: tb/sim_osc_freq_detect.sv
module sim_osc_freq_detect;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0, rst_n = 1'b0, osc = 1'b0, refc = 1'b0;
  logic sel = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  realtime osc_half = 5.0;
  realtime ref_half = 2500.0;
  int checks = 0, errors = 0;

  localparam int BASE [4] = '{732, 794, 1172, 1587};
  localparam logic [31:0] FM = 32'h3000_0000;

  osc_freq_detect u0 (
    .clk_i(clk), .rst_ni(rst_n), .osc_clk_i(osc), .ref_clk_i(refc),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  always #2 clk = ~clk;
  initial forever #(osc_half) osc = ~osc;
  initial begin
    #1.0;
    forever #(ref_half) refc = ~refc;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    int n;
    n = 0;
    rd(2'd1, s);
    while (s[31] && n < 45000) begin
      rd(2'd1, s);
      n++;
    end
    if (s[31]) begin
      checks++; errors++;
      $display("FAIL %s busy stuck act=1 exp=0", req);
    end
  endtask

  task automatic measure(input int c, input int n, input logic [31:0] ctrl_init);
    logic [31:0] s, v;
    int code;
    bit hit;
    ref_half = c * 5.0 / (n + 1);
    wr(2'd2, ctrl_init);
    @(posedge refc);
    wr(2'd0, 32'h8000_0000 | 32'(n));
    rd(2'd1, s);
    chk("R2 busy after trigger", {31'b0, s[31]}, 32'd1);
    wait_idle("R2");
    rd(2'd0, v);
    chk("R3 window readback", v, 32'(n));
    rd(2'd1, s);
    chk("R3 count", {16'b0, s[15:0]}, 32'(c));
    hit = 1'b0; code = 0;
    for (int k = 0; k < 4; k++) begin
      int t;
      t = BASE[k] * (n + 1) / 2;
      if (!hit && c >= t - 3 && c <= t + 3) begin hit = 1'b1; code = k; end
    end
    chk(hit ? "R5 match flag" : "R7 match flag", {31'b0, s[30]}, {31'b0, hit});
    rd(2'd2, v);
    chk(hit ? "R6 ctrl field" : "R7 ctrl kept", v,
        hit ? ((ctrl_init & ~FM) | (32'(code) << 28)) : ctrl_init);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int dl [4];
    dl = '{-4, -3, 3, 4};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'd1, v); chk("R1 status reset", v, 32'h0);
    rd(2'd0, v); chk("R1 window reset", v, 32'h0);
    rd(2'd2, v); chk("R1 osc ctrl reset", v, 32'h1000_0000);

    wr(2'd2, 32'hA5A5_5A5A);
    rd(2'd2, v); chk("R9 ctrl readback", v, 32'hA5A5_5A5A);

    // tolerance band edges for every code, window 1
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 4; j++) begin
        measure(BASE[k] + dl[j], 1, (32'h5A5A_A5A5 & ~FM) | (32'((k + 1) % 4) << 28));
      end
    end

    // other windows scale the targets
    measure(366, 0, 32'h0F00_00F0);
    measure(1761, 2, 32'h3000_0001);
    measure(1590, 3, 32'h0000_0000);
    measure(1760, 1, 32'h2222_2222);

    // R8: trigger during busy ignored
    ref_half = 732 * 2.5;
    wr(2'd2, 32'h1000_0000);
    @(posedge refc);
    wr(2'd0, 32'h8000_0001);
    wr(2'd0, 32'h8000_0003);
    rd(2'd0, v); chk("R8 window unchanged", v, 32'd1);
    wait_idle("R8");
    rd(2'd1, v); chk("R8 count from first window", {16'b0, v[15:0]}, 32'd732);
    rd(2'd2, v); chk("R8 ctrl", v, 32'h0000_0000);

    // R4: counter saturation with a fast oscillator
    osc_half = 0.25;
    ref_half = 20000.0;
    wr(2'd2, 32'h1234_5678);
    @(posedge refc);
    wr(2'd0, 32'h8000_0000);
    wait_idle("R4");
    rd(2'd1, v);
    chk("R4 saturated count", {16'b0, v[15:0]}, 32'h0000_FFFF);
    chk("R7 no match on saturation", {31'b0, v[30]}, 32'd0);
    rd(2'd2, v); chk("R7 ctrl kept on saturation", v, 32'h1234_5678);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule